// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block runs single command, address or data cycles on an asynchronous NAND flash bus, one byte wide by default. A host hands it one request at a time. Each request gives a kind (command, address or data), a direction for data cycles, and a write byte. The block then walks a fixed phase order and drives the chip enables, the command and address latch enables, the write and read strobes, and the output enable of the data bus. Every phase length comes from its own programmable timing field. It counts clock cycles for those fields.

Each access starts with an address-setup phase. A strobe phase follows, and it is stretched while the device holds its wait line low. A hold phase comes last. A read data cycle that directly follows a command or address cycle first waits out a latch-to-read gap. On writes, the data bus stays released for a programmable number of cycles from the start of the access. The host sees a one-cycle done pulse as the sequencer returns to idle. Captured read data stays on the response port until the next read completes.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset all chip enables and both strobes are high, both latch enables and the bus output enable are low, ready is high, done is low, the bank field is 0 and every timing field is 0, so the first access has 1 setup, 1 strobe and 1 hold cycle.
- R2: An accepted request turns the selected chip enable low on the next cycle. The strobe falls after exactly setup+1 busy cycles (setup field, config index 5), plus any read gap from R6.
- R3: With the wait input high, the strobe lasts stretch+1 cycles (config index 4). The strobe never ends in a cycle where wait is low, and it lasts stretch+1 cycles after the last low-wait cycle.
- R4: After the strobe, the access stays busy for hold+1 cycles (config index 3), with the latch enables, the write byte and the chip enable unchanged. In the following cycle the sequencer is idle and done is high for exactly one cycle.
- R5: On a write the bus output enable stays low for the first hz cycles of the access (config index 2; 0 gives none, 255 gives 255) and is high from then until the access ends. A read never drives the bus.
- R6: A data read accepted right after a command access is preceded by cle_gap+1 busy cycles (config index 0, 4 bits, 0 gives 1, 15 gives 16). A read right after an address access is preceded by ale_gap+1 cycles (index 1, same encoding). Any other access has no gap.
- R7: Read data is sampled on the clock edge that ends the low read strobe. It appears on the response port by the done cycle and holds until the next read ends.
- R8: Request kind 2'b00 is a command (the command latch enable is high through setup, strobe and hold) and 2'b01 is an address (the address latch enable is high instead). 2'b10 and 2'b11 are data. For commands and addresses the write flag is ignored and the access is always a write.
- R9: Config index 6 selects the bank. Only that bank's chip enable goes low, and it stays low for the whole access.
- R10: Config writes are taken only while the sequencer is idle. A write issued during an access leaves the field unchanged.
- R11: The write and read strobes are never low together, and the two latch enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing/bank field write strobe |
| cfg_idx | input | 3 | Field index (0 cle_gap, 1 ale_gap, 2 hz, 3 hold, 4 stretch, 5 setup, 6 bank) |
| cfg_wdata | input | 8 | Field value (short fields use the low bits) |
| req_valid | input | 1 | Request present; taken when ready is high |
| req_kind | input | 2 | 00 command, 01 address, 1x data |
| req_write | input | 1 | Direction of a data cycle (1 write) |
| req_wdata | input | 8 | Byte driven on writes |
| req_ready | output | 1 | Sequencer idle |
| req_done | output | 1 | One-cycle pulse when an access completes |
| rsp_rdata | output | 8 | Last byte read |
| nand_wait_n | input | 1 | Device wait, active low |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data in |

## Verification
The bound checker watches every cycle for these properties: the two strobes never overlap, the latch enables never overlap, at most one chip enable is low, a strobe that sees wait low is still low on the next cycle, a read never coincides with a driven bus, and done is a single-cycle pulse that follows a busy cycle. Exact phase lengths cannot be shown by those properties. The same holds for the gap selection after command or address cycles, the Hi-Z count, the captured read byte and the refusal of config writes during an access. The bench's scoreboard measures those at the pins over accesses at minimum and maximum field values.

// File: rtl/nand_strobe_seq_pkg.sv
package nand_strobe_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_GAP    = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      KIND_CMD  = 2'd0,
      KIND_ADDR = 2'd1,
      KIND_DATA = 2'd2
   } kind_e;

   localparam int unsigned IDX_CLE_GAP = 0;
   localparam int unsigned IDX_ALE_GAP = 1;
   localparam int unsigned IDX_HZ      = 2;
   localparam int unsigned IDX_HOLD    = 3;
   localparam int unsigned IDX_STRETCH = 4;
   localparam int unsigned IDX_SETUP   = 5;
   localparam int unsigned IDX_BANK    = 6;
   localparam int unsigned IDX_W       = 3;

   function automatic kind_e decode_kind(input logic [1:0] code);
      if (code[1]) return KIND_DATA;
      else if (code[0]) return KIND_ADDR;
      else return KIND_CMD;
   endfunction

   function automatic logic is_write(input kind_e k, input logic wr);
      return (k != KIND_DATA) || wr;
   endfunction

endpackage

// File: rtl/nand_strobe_cfg.sv
module nand_strobe_cfg
   import nand_strobe_seq_pkg::*;
#(
   parameter int unsigned LONG_W  = 8,
   parameter int unsigned SHORT_W = 4,
   parameter int unsigned BANK_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idle,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [LONG_W-1:0]  wr_data,
   output logic [SHORT_W-1:0] t_cle_gap,
   output logic [SHORT_W-1:0] t_ale_gap,
   output logic [LONG_W-1:0]  t_hz,
   output logic [LONG_W-1:0]  t_hold,
   output logic [LONG_W-1:0]  t_stretch,
   output logic [LONG_W-1:0]  t_setup,
   output logic [BANK_W-1:0]  bank_sel
);

   logic take;
   assign take = wr_en && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_cle_gap <= '0;
         t_ale_gap <= '0;
         t_hz      <= '0;
         t_hold    <= '0;
         t_stretch <= '0;
         t_setup   <= '0;
         bank_sel  <= '0;
      end else if (take) begin
         case (wr_idx)
            IDX_W'(IDX_CLE_GAP): t_cle_gap <= wr_data[SHORT_W-1:0];
            IDX_W'(IDX_ALE_GAP): t_ale_gap <= wr_data[SHORT_W-1:0];
            IDX_W'(IDX_HZ):      t_hz      <= wr_data;
            IDX_W'(IDX_HOLD):    t_hold    <= wr_data;
            IDX_W'(IDX_STRETCH): t_stretch <= wr_data;
            IDX_W'(IDX_SETUP):   t_setup   <= wr_data;
            IDX_W'(IDX_BANK):    bank_sel  <= wr_data[BANK_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/nand_strobe_fsm.sv
module nand_strobe_fsm
   import nand_strobe_seq_pkg::*;
#(
   parameter int unsigned LONG_W  = 8,
   parameter int unsigned SHORT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic               req_write,
   input  logic               wait_n,
   input  logic [SHORT_W-1:0] t_cle_gap,
   input  logic [SHORT_W-1:0] t_ale_gap,
   input  logic [LONG_W-1:0]  t_setup,
   input  logic [LONG_W-1:0]  t_stretch,
   input  logic [LONG_W-1:0]  t_hold,
   output phase_e             phase,
   output kind_e              cur_kind,
   output logic               cur_write,
   output logic               accept,
   output logic               accept_write,
   output logic               strobe_end,
   output logic               done
);

   logic [LONG_W-1:0]  cnt;
   logic [SHORT_W-1:0] gap_len;
   kind_e              last_kind;
   kind_e              in_kind;

   assign in_kind      = decode_kind(req_kind);
   assign accept       = (phase == PH_IDLE) && req_valid;
   assign accept_write = is_write(in_kind, req_write);
   assign strobe_end   = (phase == PH_STROBE) && wait_n && (cnt == t_stretch);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         gap_len   <= '0;
         cur_kind  <= KIND_DATA;
         cur_write <= 1'b0;
         last_kind <= KIND_DATA;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  cur_kind  <= in_kind;
                  cur_write <= accept_write;
                  last_kind <= in_kind;
                  cnt       <= '0;
                  if (!accept_write && last_kind == KIND_CMD) begin
                     gap_len <= t_cle_gap;
                     phase   <= PH_GAP;
                  end else if (!accept_write && last_kind == KIND_ADDR) begin
                     gap_len <= t_ale_gap;
                     phase   <= PH_GAP;
                  end else begin
                     phase   <= PH_SETUP;
                  end
               end
            end
            PH_GAP: begin
               if (cnt == LONG_W'(gap_len)) begin
                  cnt   <= '0;
                  phase <= PH_SETUP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_SETUP: begin
               if (cnt == t_setup) begin
                  cnt   <= '0;
                  phase <= PH_STROBE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STROBE: begin
               if (!wait_n) begin
                  cnt <= '0;
               end else if (cnt == t_stretch) begin
                  cnt   <= '0;
                  phase <= PH_HOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt == t_hold) begin
                  cnt   <= '0;
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nand_strobe_pins.sv
module nand_strobe_pins
   import nand_strobe_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LONG_W    = 8,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  phase_e               phase,
   input  kind_e                cur_kind,
   input  logic                 cur_write,
   input  logic                 accept,
   input  logic                 accept_write,
   input  logic                 strobe_end,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic [LONG_W-1:0]    t_hz,
   input  logic [DATA_W-1:0]    dq_in,
   output logic [NUM_BANKS-1:0] ce_n,
   output logic                 cle,
   output logic                 ale,
   output logic                 we_n,
   output logic                 re_n,
   output logic [DATA_W-1:0]    dq_out,
   output logic                 dq_oe,
   output logic [DATA_W-1:0]    rdata
);

   logic [BANK_W-1:0] cur_bank;
   logic [DATA_W-1:0] wdata_q;
   logic [LONG_W-1:0] hz_left;
   logic              busy;
   logic              latch_win;
   logic              strobe_on;

   assign busy      = (phase != PH_IDLE);
   assign latch_win = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobe_on = (phase == PH_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_bank <= '0;
         wdata_q  <= '0;
         hz_left  <= '0;
         rdata    <= '0;
      end else begin
         if (accept) begin
            cur_bank <= bank_sel;
            wdata_q  <= req_wdata;
            hz_left  <= accept_write ? t_hz : '0;
         end else if (busy && hz_left != '0) begin
            hz_left <= hz_left - 1'b1;
         end
         if (strobe_end && !cur_write) begin
            rdata <= dq_in;
         end
      end
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ce
      assign ce_n[g] = !(busy && cur_bank == BANK_W'(g));
   end

   assign cle    = latch_win && (cur_kind == KIND_CMD);
   assign ale    = latch_win && (cur_kind == KIND_ADDR);
   assign we_n   = !(strobe_on && cur_write);
   assign re_n   = !(strobe_on && !cur_write);
   assign dq_out = wdata_q;
   assign dq_oe  = busy && cur_write && (hz_left == '0);

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nand_strobe_seq_pkg::*;
#(
   parameter int unsigned BUS_BYTES = 1,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned LONG_W    = 8,
   parameter int unsigned SHORT_W   = 4,
   localparam int unsigned DATA_W   = 8 * BUS_BYTES,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [LONG_W-1:0]    cfg_wdata,
   input  logic                 req_valid,
   input  logic [1:0]           req_kind,
   input  logic                 req_write,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 req_ready,
   output logic                 req_done,
   output logic [DATA_W-1:0]    rsp_rdata,
   input  logic                 nand_wait_n,
   output logic [NUM_BANKS-1:0] nand_ce_n,
   output logic                 nand_cle,
   output logic                 nand_ale,
   output logic                 nand_we_n,
   output logic                 nand_re_n,
   output logic [DATA_W-1:0]    nand_dq_out,
   output logic                 nand_dq_oe,
   input  logic [DATA_W-1:0]    nand_dq_in
);

   if (BUS_BYTES < 1 || BUS_BYTES > 2) begin : g_bad_bus
      $error("BUS_BYTES must be 1 or 2");
   end
   if (NUM_BANKS < 2 || NUM_BANKS > 16) begin : g_bad_banks
      $error("NUM_BANKS must be 2..16");
   end
   if (SHORT_W > LONG_W || BANK_W > LONG_W) begin : g_bad_widths
      $error("short fields and bank must fit in LONG_W");
   end

   logic [SHORT_W-1:0] t_cle_gap, t_ale_gap;
   logic [LONG_W-1:0]  t_hz, t_hold, t_stretch, t_setup;
   logic [BANK_W-1:0]  bank_sel;
   phase_e             phase;
   kind_e              cur_kind;
   logic               cur_write, accept, accept_write, strobe_end;

   assign req_ready = (phase == PH_IDLE);

   nand_strobe_cfg #(
      .LONG_W (LONG_W),
      .SHORT_W(SHORT_W),
      .BANK_W (BANK_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (req_ready),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_data  (cfg_wdata),
      .t_cle_gap(t_cle_gap),
      .t_ale_gap(t_ale_gap),
      .t_hz     (t_hz),
      .t_hold   (t_hold),
      .t_stretch(t_stretch),
      .t_setup  (t_setup),
      .bank_sel (bank_sel)
   );

   nand_strobe_fsm #(
      .LONG_W (LONG_W),
      .SHORT_W(SHORT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_kind    (req_kind),
      .req_write   (req_write),
      .wait_n      (nand_wait_n),
      .t_cle_gap   (t_cle_gap),
      .t_ale_gap   (t_ale_gap),
      .t_setup     (t_setup),
      .t_stretch   (t_stretch),
      .t_hold      (t_hold),
      .phase       (phase),
      .cur_kind    (cur_kind),
      .cur_write   (cur_write),
      .accept      (accept),
      .accept_write(accept_write),
      .strobe_end  (strobe_end),
      .done        (req_done)
   );

   nand_strobe_pins #(
      .DATA_W   (DATA_W),
      .LONG_W   (LONG_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_W   (BANK_W)
   ) u_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .cur_kind    (cur_kind),
      .cur_write   (cur_write),
      .accept      (accept),
      .accept_write(accept_write),
      .strobe_end  (strobe_end),
      .req_wdata   (req_wdata),
      .bank_sel    (bank_sel),
      .t_hz        (t_hz),
      .dq_in       (nand_dq_in),
      .ce_n        (nand_ce_n),
      .cle         (nand_cle),
      .ale         (nand_ale),
      .we_n        (nand_we_n),
      .re_n        (nand_re_n),
      .dq_out      (nand_dq_out),
      .dq_oe       (nand_dq_oe),
      .rdata       (rsp_rdata)
   );

endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
   parameter int unsigned NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_done,
   input logic                 nand_wait_n,
   input logic [NUM_BANKS-1:0] nand_ce_n,
   input logic                 nand_cle,
   input logic                 nand_ale,
   input logic                 nand_we_n,
   input logic                 nand_re_n,
   input logic                 nand_dq_oe
);

   logic strobe, busy;
   assign strobe = !nand_we_n || !nand_re_n;
   assign busy   = !(&nand_ce_n);

   a_r11_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   a_r11_latches_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   a_r9_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));

   a_r3_wait_keeps_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !nand_wait_n) |=> strobe);

   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> (!busy && $past(busy)));

   a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

   a_r5_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      nand_dq_oe |-> busy);

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_done   (req_done),
   .nand_wait_n(nand_wait_n),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [7:0] cfg_wdata = '0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic       req_write = 1'b0;
   logic [7:0] req_wdata = '0;
   logic       req_ready, req_done;
   logic [7:0] rsp_rdata;
   logic       nand_wait_n = 1'b1;
   logic [3:0] nand_ce_n;
   logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0] nand_dq_out;
   logic [7:0] nand_dq_in = '0;

   always #10 clk = ~clk;

   nand_strobe_seq u_nand_strobe_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
      .req_wdata(req_wdata), .req_ready(req_ready), .req_done(req_done),
      .rsp_rdata(rsp_rdata), .nand_wait_n(nand_wait_n), .nand_ce_n(nand_ce_n),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit         rd;
      int         pre;
      int         str;
      int         post;
      int         cle;
      int         ale;
      int         oe_lo;
      logic [7:0] wd;
      logic [3:0] ce;
      logic [7:0] rdata;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   int m_setup = 0, m_stretch = 0, m_hold = 0, m_hz = 0, m_cgap = 0, m_agap = 0, m_bank = 0;
   int m_last = 2;
   logic [7:0] m_rd = '0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic cfg_write(int idx, int val, bit apply);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = 8'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      if (apply) begin
         case (idx)
            0: m_cgap = val & 15;
            1: m_agap = val & 15;
            2: m_hz = val;
            3: m_hold = val;
            4: m_stretch = val;
            5: m_setup = val;
            6: m_bank = val & 3;
            default: ;
         endcase
      end
   endtask

   // driver: computes expectations from the requirements and pushes them
   task automatic access(int kcode, bit wr, logic [7:0] wd, logic [7:0] din,
                         int wait_lo, bit poke_busy, string tag);
      exp_t e;
      int   kind, gap, total;
      bit   eff_wr;
      kind   = (kcode >= 2) ? 2 : kcode;                 // R8 decode
      eff_wr = (kind != 2) || wr;
      gap    = (!eff_wr && m_last == 0) ? m_cgap + 1 :
               (!eff_wr && m_last == 1) ? m_agap + 1 : 0; // R6
      e.rd    = !eff_wr;
      e.pre   = gap + m_setup + 1;                        // R2
      e.str   = wait_lo + m_stretch + 1;                  // R3
      e.post  = m_hold + 1;                               // R4
      total   = e.pre + e.str + e.post;
      e.cle   = (kind == 0) ? (m_setup + 1 + e.str + e.post) : 0;
      e.ale   = (kind == 1) ? (m_setup + 1 + e.str + e.post) : 0;
      e.oe_lo = eff_wr ? m_hz : total;                    // R5
      e.wd    = wd;
      e.ce    = ~(4'b0001 << m_bank);                     // R9
      if (!eff_wr) m_rd = din;                            // R7
      e.rdata = m_rd;
      m_last  = kind;
      exp_q.push_back(e);
      tag_q.push_back(tag);

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kcode); req_write = wr; req_wdata = wd;
      nand_dq_in = din;
      nand_wait_n = (wait_lo > 0) ? 1'b0 : 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke_busy) begin
         cfg_write(5, 9, 1'b0);                           // R10: not applied
      end
      if (wait_lo > 0) begin
         while (nand_we_n && nand_re_n) @(negedge clk);
         repeat (wait_lo) @(negedge clk);
         nand_wait_n = 1'b1;
      end
      forever begin
         @(negedge clk);
         if (req_done) break;
      end
   endtask

   // monitor: measures each access at the pins and compares on done
   bit         active = 1'b0, seen_str, oe_seen, saw_re, ce_moved;
   int         s_pre, s_str, s_post, s_cle, s_ale, s_oe_lo;
   logic [7:0] s_wd;
   logic [3:0] s_ce;

   always @(negedge clk) begin
      if (rst_n) begin
         if (nand_ce_n != 4'hF) begin
            if (!active) begin
               active = 1'b1; seen_str = 1'b0; oe_seen = 1'b0; saw_re = 1'b0;
               ce_moved = 1'b0; s_pre = 0; s_str = 0; s_post = 0; s_cle = 0;
               s_ale = 0; s_oe_lo = 0; s_wd = '0; s_ce = nand_ce_n;
            end
            if (nand_ce_n != s_ce) ce_moved = 1'b1;
            if (!nand_we_n || !nand_re_n) begin
               s_str++; seen_str = 1'b1;
               if (!nand_re_n) saw_re = 1'b1;
               if (!nand_we_n) s_wd = nand_dq_out;
            end else if (!seen_str) s_pre++;
            else s_post++;
            if (nand_cle) s_cle++;
            if (nand_ale) s_ale++;
            if (nand_dq_oe) oe_seen = 1'b1;
            else if (!oe_seen) s_oe_lo++;
         end
         if (req_done) begin
            if (exp_q.size() == 0) begin
               chk("R4", "done without pending access", 1, 0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, "read strobe used (R8)", int'(saw_re), int'(e.rd));
               chk(t, "pre-strobe cycles (R2/R6)", s_pre, e.pre);
               chk(t, "strobe cycles (R3)", s_str, e.str);
               chk(t, "hold cycles (R4)", s_post, e.post);
               chk(t, "cle cycles (R8)", s_cle, e.cle);
               chk(t, "ale cycles (R8)", s_ale, e.ale);
               chk(t, "bus released cycles (R5)", s_oe_lo, e.oe_lo);
               chk(t, "chip enables (R9)", int'(s_ce), int'(e.ce));
               chk(t, "chip enable stable (R9)", int'(ce_moved), 0);
               if (!e.rd) chk(t, "write byte (R4)", int'(s_wd), int'(e.wd));
               chk(t, "read data (R7)", int'(rsp_rdata), int'(e.rdata));
               chk(t, "idle at done (R4)", int'(req_ready), 1);
            end
            active = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk("R4", "watchdog cycles", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "ce_n", int'(nand_ce_n), 15);
      chk("R1", "cle", int'(nand_cle), 0);
      chk("R1", "ale", int'(nand_ale), 0);
      chk("R1", "we_n", int'(nand_we_n), 1);
      chk("R1", "re_n", int'(nand_re_n), 1);
      chk("R1", "dq_oe", int'(nand_dq_oe), 0);
      chk("R1", "ready", int'(req_ready), 1);
      chk("R1", "done", int'(req_done), 0);

      access(2, 1'b1, 8'h3C, 8'h00, 0, 1'b0, "R1");       // default timing
      cfg_write(5, 2, 1'b1);
      cfg_write(4, 3, 1'b1);
      cfg_write(3, 1, 1'b1);
      cfg_write(2, 2, 1'b1);
      cfg_write(0, 4, 1'b1);
      cfg_write(1, 6, 1'b1);
      access(0, 1'b1, 8'h70, 8'h00, 0, 1'b0, "R8");
      access(2, 1'b0, 8'h00, 8'hA5, 0, 1'b0, "R6");       // gap after cmd
      cfg_write(6, 2, 1'b1);
      access(1, 1'b1, 8'h12, 8'h00, 0, 1'b0, "R9");
      access(2, 1'b0, 8'h00, 8'h5A, 4, 1'b0, "R3");       // gap after addr + wait
      cfg_write(2, 0, 1'b1);
      access(3, 1'b1, 8'hC3, 8'h00, 2, 1'b0, "R5");
      access(2, 1'b0, 8'h00, 8'h81, 0, 1'b0, "R6");       // no gap after data
      access(0, 1'b0, 8'hFF, 8'h00, 0, 1'b0, "R8");       // write flag ignored
      cfg_write(6, 3, 1'b1);
      access(2, 1'b1, 8'h44, 8'h00, 0, 1'b1, "R10");
      access(2, 1'b1, 8'h55, 8'h00, 0, 1'b0, "R10");      // old setup kept
      cfg_write(5, 255, 1'b1);
      cfg_write(4, 255, 1'b1);
      cfg_write(3, 255, 1'b1);
      cfg_write(0, 15, 1'b1);
      cfg_write(2, 255, 1'b1);
      access(0, 1'b1, 8'h90, 8'h00, 0, 1'b0, "R5");       // max hz
      access(2, 1'b0, 8'h00, 8'h99, 0, 1'b0, "R6");       // max gap
      cfg_write(5, 0, 1'b1);
      cfg_write(4, 0, 1'b1);
      cfg_write(3, 0, 1'b1);
      access(2, 1'b0, 8'h00, 8'h17, 3, 1'b0, "R3");       // min timing, wait
      repeat (4) @(negedge clk);
      chk("R4", "pending accesses", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule